// File: doc/BRIEF.md
# Burst-of-Four Split-Port SRAM Model

A synthesizable behavioural model of a static memory with one read port and one write port that share an address bus but keep their data paths apart. Read data leaves only on `q`, and write data enters only on `d`. Every access moves a burst of four words. The array depth is set by a parameter, so the model stays small enough for block-level simulation of the controller that drives it.

The model runs on a single clock `clk` at twice the burst clock rate. The input `k_edge` marks which `clk` rise is a K rise; the rise between two K rises is the K-bar rise. A read is requested at a K rise, and the read address is taken at that same edge. A write is requested at a K rise, and its address is taken at the K-bar rise that follows. Data beats move on every half-cycle.

The bits of a beat are split into 9-bit lanes. Each lane has its own active-low write select. A read returns the newest contents of a word, including write beats that land during the read burst itself. An output-enable flag stands in for the three-stated bus: it is high only while a read beat is on `q`.

Top module: `qdr_burst_sram`

## Requirements
- R1: While reset is held and just after it is released, `q_valid` and `q_oe` are 0 and `q` is all zeros.
- R2: A read is accepted at a K edge when `rd_n` is 0, unless the previous rule forbids it. If it is accepted at edge n, its four beats appear on `q` with `q_valid` high after edges n+2, n+3, n+4 and n+5.
- R3: The beats of a burst go to the words whose addresses are the captured address with its two low bits replaced by 0, 1, 2 and 3, in that order. The two low address bits are ignored.
- R4: A read request at the K edge right after an accepted read is ignored. A request one K edge later is accepted, and its beats follow the previous burst with no gap.
- R5: A write is accepted at a K edge when `wr_n` is 0 and no write burst is in progress. Beat 0 is taken from `d` at that edge. The address is taken at the next edge (a K-bar edge) together with beat 1. Beats 2 and 3 are taken at the next two edges.
- R6: A write request at the K edge right after an accepted write is ignored. Its data is used only as beat 2 of the write already in progress.
- R7: Bit lane i of a beat is `d[9*i+8:9*i]`. It is written only when `bw_n[i]` is 0 for that beat. A beat with every `bw_n` bit at 1 leaves the word unchanged.
- R8: `q_oe` always equals `q_valid`, and `q` is all zeros whenever `q_valid` is 0.
- R9: A read beat returns its word with every write beat applied that has committed at or before the edge where the read beat is registered. Beats 0 and 1 commit at the write's address edge, and beats 2 and 3 commit at their own edges. As a result, a write to the same burst that is accepted at the same K edge as the read, or one K edge earlier, returns its new data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; every rising edge is one half-cycle |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| k_edge | input | 1 | 1 on K rises, 0 on K-bar rises; alternates every edge |
| rd_n | input | 1 | Active-low read request, sampled on K rises |
| wr_n | input | 1 | Active-low write request, sampled on K rises |
| addr | input | AW | Shared burst address (read on K, write on K-bar) |
| bw_n | input | NB | Active-low write select per 9-bit lane, per beat |
| d | input | NB*9 | Write data beat |
| q | output | NB*9 | Read data beat, zero when idle |
| q_oe | output | 1 | Output enable of the read bus |
| q_valid | output | 1 | A read beat is on `q` |

## Verification
The bench goes after the edges where a read beat and a write beat meet. If the design used the old stored word when a write to the same word commits on the same edge, it would return stale data in the forwarding runs. If it forwarded from writes that had not yet committed, the mixed old-and-new burst would show the new data in the wrong beats. The bench also sends reads at consecutive K edges and writes at consecutive K edges. A design without the throttle would start a second burst, which would garble `q` or overwrite another burst. Lane masks are swept through all four patterns in every beat position. An address whose low bits are not zero checks that the burst order starts at the aligned base.

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram #(
  parameter int AW   = 6,
  parameter int NB   = 2,
  parameter int LANE = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               k_edge,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic [AW-1:0]      addr,
  input  logic [NB-1:0]      bw_n,
  input  logic [NB*LANE-1:0] d,
  output logic [NB*LANE-1:0] q,
  output logic               q_oe,
  output logic               q_valid
);

  localparam int W     = NB * LANE;
  localparam int BW    = AW - 2;
  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  mem [DEPTH];

  logic          rd_pend;
  logic [BW-1:0] rd_base, out_base;
  logic [1:0]    out_cnt;
  logic [1:0]    wst;
  logic [BW-1:0] wr_base;
  logic [W-1:0]  wb0_d;
  logic [NB-1:0] wb0_m;
  logic [W-1:0]  q_r;
  logic          qv_r;

  function automatic logic [W-1:0] merge(input logic [W-1:0] old,
                                         input logic [W-1:0] nw,
                                         input logic [NB-1:0] msk);
    logic [W-1:0] r;
    r = old;
    for (int i = 0; i < NB; i++)
      if (!msk[i]) r[i*LANE +: LANE] = nw[i*LANE +: LANE];
    return r;
  endfunction

  wire unused_lo = ^addr[1:0];

  wire rd_take = k_edge & ~rd_n & ~rd_pend;
  wire wr_take = k_edge & ~wr_n & (wst == 2'd0);

  wire          a_en   = (wst != 2'd0);
  wire          b_en   = (wst == 2'd1);
  wire [AW-1:0] a_addr = b_en ? {addr[AW-1:2], 2'b00} : {wr_base, wst};
  wire [AW-1:0] b_addr = {addr[AW-1:2], 2'b01};
  wire [W-1:0]  a_dat  = b_en ? wb0_d : d;
  wire [NB-1:0] a_msk  = b_en ? wb0_m : bw_n;

  wire          f_start = k_edge & rd_pend;
  wire          fetch   = f_start | (out_cnt != 2'd0);
  wire [AW-1:0] f_addr  = f_start ? {rd_base, 2'b00} : {out_base, out_cnt};

  logic [W-1:0] f_dat;
  always_comb begin
    f_dat = mem[f_addr];
    if (a_en && a_addr == f_addr) f_dat = merge(f_dat, a_dat, a_msk);
    if (b_en && b_addr == f_addr) f_dat = merge(f_dat, d, bw_n);
  end

  always_ff @(posedge clk) begin
    if (a_en) mem[a_addr] <= merge(mem[a_addr], a_dat, a_msk);
    if (b_en) mem[b_addr] <= merge(mem[b_addr], d, bw_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend  <= 1'b0;
      rd_base  <= '0;
      out_base <= '0;
      out_cnt  <= 2'd0;
      q_r      <= '0;
      qv_r     <= 1'b0;
    end else begin
      if (k_edge) rd_pend <= rd_take;
      if (rd_take) rd_base <= addr[AW-1:2];
      if (f_start) begin
        out_base <= rd_base;
        out_cnt  <= 2'd1;
      end else if (out_cnt != 2'd0) begin
        out_cnt <= out_cnt + 2'd1;
      end
      q_r  <= fetch ? f_dat : '0;
      qv_r <= fetch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wst     <= 2'd0;
      wr_base <= '0;
      wb0_d   <= '0;
      wb0_m   <= '1;
    end else begin
      case (wst)
        2'd0: if (wr_take) begin
          wst   <= 2'd1;
          wb0_d <= d;
          wb0_m <= bw_n;
        end
        2'd1: begin
          wr_base <= addr[AW-1:2];
          wst     <= 2'd2;
        end
        2'd2: wst <= 2'd3;
        default: wst <= 2'd0;
      endcase
    end
  end

  assign q       = q_r;
  assign q_valid = qv_r;
  assign q_oe    = qv_r;

  AST_K_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n) k_edge |=> !k_edge); // R5
  AST_K_RETURNS: assert property (@(posedge clk) disable iff (!rst_n) !k_edge |=> k_edge); // R5
  AST_WR_ADDR_ON_KBAR: assert property (@(posedge clk) disable iff (!rst_n) (wst == 2'd1) |-> !k_edge); // R5
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) $rose(q_valid) |-> $past(k_edge & ~rd_n, 3)); // R2
  AST_BURST_START_ON_K: assert property (@(posedge clk) disable iff (!rst_n) $rose(q_valid) |-> $past(k_edge)); // R3
  AST_BURST_END_ON_K: assert property (@(posedge clk) disable iff (!rst_n) $fell(q_valid) |-> $past(k_edge)); // R3
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !q_oe |-> (q == '0)); // R8

endmodule

// File: tb/test_qdr_burst_sram.sv
module test_qdr_burst_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        k_edge = 1'b1;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [5:0]  addr = '0;
  logic [1:0]  bw_n = 2'b11;
  logic [17:0] d = '0;
  logic [17:0] q;
  logic        q_oe, q_valid;

  qdr_burst_sram i_qdr_burst_sram (
    .clk(clk), .rst_n(rst_n), .k_edge(k_edge), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .bw_n(bw_n), .d(d), .q(q), .q_oe(q_oe), .q_valid(q_valid)
  );

  always #2 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    kph = 1'b1;

  logic [17:0] refm [64];
  bit          mpend;
  logic [3:0]  mpb, mob, mwb;
  logic [1:0]  mcnt, mw;
  logic [17:0] wb0d;
  logic [1:0]  wb0m;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic commit(input int a, input logic [17:0] dv, input logic [1:0] m);
    for (int i = 0; i < 2; i++)
      if (!m[i]) refm[a][i*9 +: 9] = dv[i*9 +: 9];
  endtask

  function automatic logic [17:0] dat(input int n);
    return 18'((n * 40503 + 12345) & 32'h3ffff);
  endfunction

  task automatic half(input bit r, input bit w, input logic [5:0] a,
                      input logic [1:0] m, input logic [17:0] dv);
    bit          ke, ev;
    logic [17:0] eq;
    rd_n = r; wr_n = w; addr = a; bw_n = m; d = dv; k_edge = kph;
    ke = kph;
    @(posedge clk);
    #1;
    if (mw == 2'd1) begin
      mwb = a[5:2];
      commit({a[5:2], 2'd0}, wb0d, wb0m);
      commit({a[5:2], 2'd1}, dv, m);
      mw = 2'd2;
    end else if (mw == 2'd2) begin
      commit({mwb, 2'd2}, dv, m);
      mw = 2'd3;
    end else if (mw == 2'd3) begin
      commit({mwb, 2'd3}, dv, m);
      mw = 2'd0;
    end else if (ke && !w) begin
      wb0d = dv; wb0m = m; mw = 2'd1;
    end
    ev = 1'b0; eq = '0;
    if (ke && mpend) begin
      ev = 1'b1; eq = refm[{mpb, 2'd0}]; mob = mpb; mcnt = 2'd1;
    end else if (mcnt != 2'd0) begin
      ev = 1'b1; eq = refm[{mob, mcnt}]; mcnt = mcnt + 2'd1;
    end
    if (ke) begin
      if (!r && !mpend) mpb = a[5:2];
      mpend = !r && !mpend;
    end
    check(q_valid === ev, tag, {31'd0, q_valid}, {31'd0, ev});
    check(q === eq, tag, {14'd0, q}, {14'd0, eq});
    check(q_oe === q_valid, "R8", {31'd0, q_oe}, {31'd0, q_valid});
    kph = ~kph;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) half(1, 1, '0, 2'b11, '0);
  endtask

  task automatic align_k();
    if (!kph) idle(1);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mpend = 0; mpb = 0; mob = 0; mwb = 0; mcnt = 0; mw = 0; wb0d = 0; wb0m = 2'b11;
    for (int i = 0; i < 64; i++) refm[i] = '0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1; k_edge = ~k_edge;
    end
    kph = k_edge;
    // R1: state held in reset
    check(q_valid === 1'b0 && q_oe === 1'b0, "R1", {30'd0, q_valid, q_oe}, 32'd0);
    check(q === '0, "R1", {14'd0, q}, 32'd0);
    rst_n = 1'b1;
    idle(2);

    // R5: fill the whole array with back-to-back write bursts
    tag = "R5"; align_k();
    for (int b = 0; b < 16; b++) begin
      half(1, 0, '0, 2'b00, dat(b*4));
      half(1, 1, 6'(b*4), 2'b00, dat(b*4+1));
      half(1, 1, '0, 2'b00, dat(b*4+2));
      half(1, 1, '0, 2'b00, dat(b*4+3));
    end
    idle(2);

    // R2,R3: back-to-back reads, low address bits nonzero
    tag = "R2,R3"; align_k();
    for (int b = 0; b < 16; b++) begin
      half(0, 1, 6'(b*4 + (b % 4)), 2'b11, '0);
      half(1, 1, '0, 2'b11, '0);
    end
    idle(6);

    // R7: every lane mask pattern in every beat position
    tag = "R7"; align_k();
    for (int b = 0; b < 16; b++) begin
      half(1, 0, '0, 2'((b) % 4), dat(900 + b*4));
      half(1, 1, 6'(b*4), 2'((b+1) % 4), dat(901 + b*4));
      half(1, 1, '0, 2'((b+2) % 4), dat(902 + b*4));
      half(1, 1, '0, 2'((b+3) % 4), dat(903 + b*4));
    end
    for (int b = 0; b < 16; b++) begin
      half(0, 1, 6'(b*4), 2'b11, '0);
      half(1, 1, '0, 2'b11, '0);
    end
    idle(6);

    // R4: read at consecutive K edges, the middle one is dropped
    tag = "R4"; align_k();
    half(0, 1, 6'(3*4), 2'b11, '0); half(1, 1, '0, 2'b11, '0);
    half(0, 1, 6'(5*4), 2'b11, '0); half(1, 1, '0, 2'b11, '0);
    half(0, 1, 6'(7*4), 2'b11, '0); half(1, 1, '0, 2'b11, '0);
    idle(8);

    // R6: write at consecutive K edges, the second request is dropped
    tag = "R6"; align_k();
    half(1, 0, '0, 2'b00, dat(2000));
    half(1, 1, 6'(2*4), 2'b00, dat(2001));
    half(1, 0, '0, 2'b00, dat(2002));
    half(1, 1, 6'(9*4), 2'b00, dat(2003));
    half(1, 0, '0, 2'b00, dat(2010));
    half(1, 1, 6'(9*4), 2'b01, dat(2011));
    half(1, 1, '0, 2'b10, dat(2012));
    half(1, 1, '0, 2'b00, dat(2013));
    half(0, 1, 6'(2*4), 2'b11, '0); half(1, 1, '0, 2'b11, '0);
    half(1, 1, '0, 2'b11, '0);      half(1, 1, '0, 2'b11, '0);
    half(0, 1, 6'(9*4), 2'b11, '0); half(1, 1, '0, 2'b11, '0);
    idle(8);

    // R9: write and read of the same burst at the same K edge
    tag = "R9"; align_k();
    half(0, 0, 6'(4*4), 2'b00, dat(3000));
    half(1, 1, 6'(4*4), 2'b10, dat(3001));
    half(1, 1, '0, 2'b00, dat(3002));
    half(1, 1, '0, 2'b01, dat(3003));
    idle(6);
    // R9: read first, write to the same burst at the next K edge
    half(0, 1, 6'(6*4), 2'b11, '0);
    half(1, 1, '0, 2'b11, '0);
    half(1, 0, '0, 2'b00, dat(3100));
    half(1, 1, 6'(6*4), 2'b00, dat(3101));
    half(1, 1, '0, 2'b00, dat(3102));
    half(1, 1, '0, 2'b00, dat(3103));
    idle(6);
    // R9: write first, read the same burst at the next K edge
    half(1, 0, '0, 2'b00, dat(3200));
    half(1, 1, 6'(8*4), 2'b00, dat(3201));
    half(0, 1, 6'(8*4), 2'b00, dat(3202));
    half(1, 1, '0, 2'b10, dat(3203));
    idle(8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule